// File: doc/BRIEF.md
# Multi-Phase Capture Event Sequencer

This block runs one capture event for a vibration-sensing front end. A single-cycle start pulse, accepted only while the block is idle, begins a sequence of three phases that always run in the same order. The first phase records a bulk multi-channel block. Each triple sample (acceleration and two auxiliary analog channels, all 16-bit two's complement) is passed straight to the capture memory, together with a write strobe and an ascending address, until 1024 sample sets are stored.

The second phase forms a boxcar average of 256 supply-voltage readings, which is 5.12 ms of samples at 50 kHz. The third phase averages 64 internal temperature readings. Each average is latched into its own 16-bit result register. Only the low 12 bits are used, and the upper four bits read zero. When the third phase finishes, the block raises a one-cycle done pulse and returns to idle.

Sample-valid strobes that arrive outside their own phase are discarded. The ADCs, the analog front end and the register access path sit outside this block.

Top module: `capture_sequencer`

## Requirements
- R1: After reset, busy, done and wr_en are 0, and both result registers read 0x0000.
- R2: A start pulse while idle makes busy read 1 on the next cycle. A start pulse while busy has no effect: the write address sequence continues unbroken and no extra writes occur.
- R3: During the fill phase, every cycle with smp_vld high asserts wr_en in that same cycle. wr_addr steps 0, 1, ..., 1023 in order, and wr_acc, wr_aux1 and wr_aux2 equal the acc_in, aux1_in and aux2_in inputs. Exactly 1024 writes occur, and only while busy.
- R4: After the fill, the next 256 sup_vld strobes are summed. On the edge that takes the 256th strobe, sup_res becomes floor(sum/256) in bits [11:0], with bits [15:12] zero.
- R5: After the supply phase, the next 64 tmp_vld strobes are summed. On the edge that takes the 64th strobe, tmp_res becomes floor(sum/64) in bits [11:0], with bits [15:12] zero.
- R6: Strobes for a phase that is not active are ignored. sup_vld and tmp_vld during the fill do not enter the averages, and smp_vld after the fill does not assert wr_en.
- R7: done is high for exactly the one cycle after the edge that takes the last temperature strobe, and busy is already low in that cycle.
- R8: Each result register holds its previous value until its own phase completes, including through a new capture event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle capture request |
| smp_vld | input | 1 | Triple-channel sample valid |
| acc_in | input | 16 | Acceleration sample, two's complement |
| aux1_in | input | 16 | Auxiliary channel 1 sample, two's complement |
| aux2_in | input | 16 | Auxiliary channel 2 sample, two's complement |
| sup_vld | input | 1 | Supply sample valid |
| sup_in | input | 12 | Supply sample, unsigned |
| tmp_vld | input | 1 | Temperature sample valid |
| tmp_in | input | 12 | Temperature sample, unsigned |
| wr_en | output | 1 | Capture memory write strobe |
| wr_addr | output | 10 | Capture memory address |
| wr_acc | output | 16 | Acceleration write data |
| wr_aux1 | output | 16 | Auxiliary 1 write data |
| wr_aux2 | output | 16 | Auxiliary 2 write data |
| sup_res | output | 16 | Supply average, 12 bits LSB-justified |
| tmp_res | output | 16 | Temperature average, 12 bits LSB-justified |
| busy | output | 1 | Capture event in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Samples arrive with random idle gaps and random data. Supply and temperature strobes are also fired during the fill, which shows whether out-of-phase strobes leak into an average or get through to the memory. Three supply and temperature patterns are used: uniform random values, all-maximum values, and alternating 0/1 values. The all-maximum pattern exposes an accumulator that is too narrow. The alternating pattern tells a truncating average (result 0) from a rounding one. A start pulse is issued in the middle of a fill, and a second event is run with the old results still in place, which separates ignored restarts and held results from a design that clears or restarts.

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
  parameter int DW       = 16,
  parameter int RW       = 12,
  parameter int OW       = 16,
  parameter int NSAMP    = 1024,
  parameter int SUP_LOG2 = 8,
  parameter int TMP_LOG2 = 6,
  localparam int AW      = $clog2(NSAMP),
  localparam int AVGMAX  = (SUP_LOG2 > TMP_LOG2) ? SUP_LOG2 : TMP_LOG2,
  localparam int CW      = (AW > AVGMAX) ? AW : AVGMAX,
  localparam int ACCW    = RW + AVGMAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          smp_vld,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] aux1_in,
  input  logic [DW-1:0] aux2_in,
  input  logic          sup_vld,
  input  logic [RW-1:0] sup_in,
  input  logic          tmp_vld,
  input  logic [RW-1:0] tmp_in,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_acc,
  output logic [DW-1:0] wr_aux1,
  output logic [DW-1:0] wr_aux2,
  output logic [OW-1:0] sup_res,
  output logic [OW-1:0] tmp_res,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_SUP, S_TMP} state_t;

  localparam logic [CW-1:0] LAST_FILL = CW'(NSAMP - 1);
  localparam logic [CW-1:0] LAST_SUP  = CW'((1 << SUP_LOG2) - 1);
  localparam logic [CW-1:0] LAST_TMP  = CW'((1 << TMP_LOG2) - 1);

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [ACCW-1:0] acc;
  logic [ACCW-1:0] sup_sum, tmp_sum, sup_avg, tmp_avg;
  logic            sup_take, tmp_take;

  assign wr_en    = (st == S_FILL) && smp_vld;
  assign wr_addr  = cnt[AW-1:0];
  assign wr_acc   = acc_in;
  assign wr_aux1  = aux1_in;
  assign wr_aux2  = aux2_in;
  assign busy     = (st != S_IDLE);
  assign sup_take = (st == S_SUP) && sup_vld;
  assign tmp_take = (st == S_TMP) && tmp_vld;
  assign sup_sum  = acc + ACCW'(sup_in);
  assign tmp_sum  = acc + ACCW'(tmp_in);
  assign sup_avg  = sup_sum >> SUP_LOG2;
  assign tmp_avg  = tmp_sum >> TMP_LOG2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      acc     <= '0;
      sup_res <= '0;
      tmp_res <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st  <= S_FILL;
          cnt <= '0;
          acc <= '0;
        end
        S_FILL: if (wr_en) begin
          if (cnt == LAST_FILL) begin
            st  <= S_SUP;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SUP: if (sup_take) begin
          if (cnt == LAST_SUP) begin
            st      <= S_TMP;
            cnt     <= '0;
            acc     <= '0;
            sup_res <= OW'(sup_avg[RW-1:0]);
          end else begin
            cnt <= cnt + 1'b1;
            acc <= sup_sum;
          end
        end
        S_TMP: if (tmp_take) begin
          if (cnt == LAST_TMP) begin
            st      <= S_IDLE;
            cnt     <= '0;
            acc     <= '0;
            tmp_res <= OW'(tmp_avg[RW-1:0]);
            done    <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
            acc <= tmp_sum;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module capture_sequencer_chk #(
  parameter int AW = 10,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [OW-1:0] sup_res,
  input logic [OW-1:0] tmp_res,
  input logic          busy,
  input logic          done
);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_wr_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_addr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (wr_addr == '0));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_sup_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sup_res));

  assert_tmp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tmp_res));

endmodule

bind capture_sequencer capture_sequencer_chk #(.AW(AW), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
  .sup_res(sup_res), .tmp_res(tmp_res), .busy(busy), .done(done)
);

// File: tb/capture_sequencer_tb_top.sv
module capture_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        smp_vld = 1'b0, sup_vld = 1'b0, tmp_vld = 1'b0;
  logic [15:0] acc_in = '0, aux1_in = '0, aux2_in = '0;
  logic [11:0] sup_in = '0, tmp_in = '0;
  logic        wr_en, busy, done;
  logic [9:0]  wr_addr;
  logic [15:0] wr_acc, wr_aux1, wr_aux2, sup_res, tmp_res;

  int checks = 0;
  int errors = 0;
  int seed_dummy;

  always #4 clk = ~clk;

  capture_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld),
    .acc_in(acc_in), .aux1_in(aux1_in), .aux2_in(aux2_in),
    .sup_vld(sup_vld), .sup_in(sup_in), .tmp_vld(tmp_vld), .tmp_in(tmp_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_acc(wr_acc), .wr_aux1(wr_aux1),
    .wr_aux2(wr_aux2), .sup_res(sup_res), .tmp_res(tmp_res),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] gen_val(input int mode, input int i);
    case (mode)
      1:       return 12'hFFF;
      2:       return 12'(i & 1);
      default: return 12'($urandom());
    endcase
  endfunction

  function automatic logic [15:0] avg_exp(input longint sum, input int sh);
    return 16'((sum >> sh) & 64'hFFF);
  endfunction

  task automatic run_capture(input int mode);
    longint ssum = 0, tsum = 0;
    logic [15:0] old_sup, old_tmp;
    old_sup = sup_res;
    old_tmp = tmp_res;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    for (int i = 0; i < 1024; i++) begin
      while ($urandom_range(3) == 0) begin
        sup_vld = 1'b1; tmp_vld = 1'b1;
        sup_in = 12'hFFF; tmp_in = 12'hFFF;
        #1;
        check(wr_en == 1'b0, "R6 no write without smp_vld", wr_en, 0);
        @(negedge clk);
        sup_vld = 1'b0; tmp_vld = 1'b0;
      end
      smp_vld = 1'b1;
      acc_in = 16'($urandom()); aux1_in = 16'($urandom()); aux2_in = 16'($urandom());
      start = (i == 500);
      #1;
      check(wr_en && wr_addr == 10'(i), "R3 write strobe and address", {wr_en, wr_addr}, {1'b1, 10'(i)});
      check(wr_acc == acc_in && wr_aux1 == aux1_in && wr_aux2 == aux2_in,
            "R3 write data", wr_acc, acc_in);
      if (i == 600)
        check(sup_res == old_sup && tmp_res == old_tmp, "R8 results held in fill", sup_res, old_sup);
      @(negedge clk);
      smp_vld = 1'b0; start = 1'b0;
    end
    smp_vld = 1'b1;
    #1;
    check(wr_en == 1'b0, "R6 smp_vld after fill ignored", wr_en, 0);
    check(busy == 1'b1, "R2 R3 fill ended after 1024", busy, 1);
    @(negedge clk);
    smp_vld = 1'b0;
    for (int i = 0; i < 256; i++) begin
      if ($urandom_range(2) == 0) @(negedge clk);
      if (i == 255)
        check(sup_res == old_sup, "R8 sup held before last", sup_res, old_sup);
      sup_vld = 1'b1;
      sup_in = gen_val(mode, i);
      ssum += sup_in;
      @(negedge clk);
      sup_vld = 1'b0;
    end
    check(sup_res == avg_exp(ssum, 8), "R4 supply average", sup_res, avg_exp(ssum, 8));
    check(tmp_res == old_tmp, "R8 tmp held after supply", tmp_res, old_tmp);
    for (int i = 0; i < 64; i++) begin
      if ($urandom_range(2) == 0) @(negedge clk);
      tmp_vld = 1'b1;
      tmp_in = gen_val(mode, i);
      tsum += tmp_in;
      @(negedge clk);
      tmp_vld = 1'b0;
    end
    check(tmp_res == avg_exp(tsum, 6), "R5 temperature average", tmp_res, avg_exp(tsum, 6));
    check(done == 1'b1 && busy == 1'b0, "R7 done with busy low", {done, busy}, 2'b10);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    sup_vld = 1'b1; tmp_vld = 1'b1; sup_in = 12'h123; tmp_in = 12'h456;
    @(negedge clk);
    sup_vld = 1'b0; tmp_vld = 1'b0;
    check(sup_res == avg_exp(ssum, 8) && tmp_res == avg_exp(tsum, 6),
          "R6 R8 idle strobes ignored", sup_res, avg_exp(ssum, 8));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && wr_en == 0, "R1 reset flags", {busy, done, wr_en}, 0);
    check(sup_res == 0 && tmp_res == 0, "R1 reset results", {sup_res, tmp_res}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_capture(0);
    run_capture(1);
    run_capture(2);
    run_capture(0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule